// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block turns parallel bytes into a serial bit stream in one of three modes. In asynchronous mode it emits UART-style frames on a line that idles high, with a bit period taken from an 8-bit divisor and a speed select. In synchronous master mode it drives its own shift clock from the same divisor and sends the data bits with no framing. In synchronous slave mode it advances one bit for each falling edge of an external clock. One shift register serves all three modes. An optional ninth data bit comes from a separate input, and software can use it as a parity bit.

Software writes a byte into a one-entry holding buffer. The engine moves the byte into the shift register as soon as the register is free and transmission is allowed. Because of this, a second byte can wait in the buffer while the first one is shifting, and consecutive frames follow each other with no idle gap. In synchronous mode, an active receive enable takes priority over the transmit enable and holds the transmitter idle.

Top module: `sertx_engine`

## Requirements
- R1: After reset, shift_empty and buf_empty read 1, ser_out is 1 and clk_out is 0.
- R2: An asynchronous frame is sent on ser_out as follows: one 0 start bit, then the data bits least significant first, then one 1 stop bit. Between frames the line rests at 1.
- R3: In asynchronous mode every bit lasts (baud_div+1)*16 clocks when fast_baud is 0, and (baud_div+1)*4 clocks when fast_baud is 1.
- R4: With nine_bit at 1, the value of wr_bit9 captured at the write is sent as a ninth data bit after the eight data bits. With nine_bit at 0, no ninth bit is sent.
- R5: While tx_en is 0, no frame starts. A written byte stays in the buffer (buf_empty stays 0, ser_out stays 1) and is sent once tx_en goes to 1.
- R6: In synchronous mode, rx_single_en or rx_cont_en at 1 keeps the transmitter idle even when tx_en is 1. In asynchronous mode these inputs have no effect.
- R7: In synchronous master mode (sync_mode=1, clk_master=1), clk_out_en is 1. clk_out rests at 0 and, for each bit, stays low for baud_div+1 clocks and then high for baud_div+1 clocks. Data is valid at each rising edge and is sent least significant bit first, with no start or stop bit. fast_baud has no effect in this mode.
- R8: In synchronous slave mode (sync_mode=1, clk_master=0), clk_out_en is 0. The first bit is presented when the byte is loaded and is held until a falling edge of ext_clk, which is synchronised through two flops. Each falling edge advances one bit, and the frame ends after the last data bit.
- R9: In asynchronous mode clk_master has no effect: clk_out_en and clk_out stay 0, and the frame is unchanged.
- R10: A wr_strobe fills the holding buffer, so buf_empty reads 0 on the next cycle. The buffer empties when its contents move to the shift register. A byte that is waiting is sent directly after the stop bit of the current frame, with no idle clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = synchronous half-duplex, 0 = asynchronous |
| clk_master | input | 1 | Synchronous only: 1 = generate the shift clock, 0 = use ext_clk |
| nine_bit | input | 1 | 1 = send nine data bits |
| tx_en | input | 1 | Transmit enable |
| rx_single_en | input | 1 | Single-receive enable; overrides tx_en in synchronous mode |
| rx_cont_en | input | 1 | Continuous-receive enable; overrides tx_en in synchronous mode |
| fast_baud | input | 1 | Asynchronous speed select: 1 = divide by 4, 0 = divide by 16 |
| baud_div | input | 8 | Baud-rate divisor |
| wr_data | input | 8 | Byte to send |
| wr_bit9 | input | 1 | Ninth data bit, captured with wr_data |
| wr_strobe | input | 1 | Writes wr_data and wr_bit9 into the holding buffer |
| ext_clk | input | 1 | External shift clock for slave mode |
| ser_out | output | 1 | Serial data line |
| clk_out | output | 1 | Shift clock driven in master mode |
| clk_out_en | output | 1 | 1 when clk_out should drive the clock line |
| shift_empty | output | 1 | 1 when the shift register holds no frame |
| buf_empty | output | 1 | 1 when the holding buffer can take a byte |

## Verification
The properties assume that the mode, speed, clock-source and width controls stay constant while a frame is in the shift register. They also assume that wr_strobe is pulsed only while buf_empty is 1, and that ext_clk holds each level for several system clocks. The bench follows all three assumptions: it changes controls only after waiting for both status flags to read empty, it writes a second byte only after seeing the buffer empty, and it holds each ext_clk level for six clocks.

// File: rtl/sertx_engine.sv
module sertx_engine #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int LO_OVS = 16,
  parameter int HI_OVS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             clk_master,
  input  logic             nine_bit,
  input  logic             tx_en,
  input  logic             rx_single_en,
  input  logic             rx_cont_en,
  input  logic             fast_baud,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [DATA_W-1:0] wr_data,
  input  logic             wr_bit9,
  input  logic             wr_strobe,
  input  logic             ext_clk,
  output logic             ser_out,
  output logic             clk_out,
  output logic             clk_out_en,
  output logic             shift_empty,
  output logic             buf_empty
);
  localparam int SR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam int PRE_W = $clog2(LO_OVS);

  logic [DATA_W-1:0] hold_data;
  logic              hold_b9, hold_full;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  bits_left;
  logic              busy, sclk_r;
  logic [PRE_W-1:0]  pre_cnt, pre_max;
  logic [DIV_W-1:0]  div_cnt;
  logic [2:0]        ext_sync;

  logic master, tx_go, brg_tick, ext_fall, shift_evt, last_bit, take;
  logic [SR_W-1:0]  frame_img;
  logic [CNT_W-1:0] frame_len;

  assign master    = sync_mode & clk_master;
  assign tx_go     = tx_en & ~(sync_mode & (rx_single_en | rx_cont_en));
  assign pre_max   = sync_mode ? '0 : fast_baud ? PRE_W'(HI_OVS - 1) : PRE_W'(LO_OVS - 1);
  assign brg_tick  = busy & (pre_cnt == pre_max) & (div_cnt == baud_div);
  assign ext_fall  = ext_sync[2] & ~ext_sync[1];
  assign shift_evt = !sync_mode ? brg_tick : master ? (brg_tick & sclk_r) : (ext_fall & busy);
  assign last_bit  = shift_evt & (bits_left == CNT_W'(1));
  assign take      = hold_full & tx_go & (~busy | last_bit);

  assign frame_img = sync_mode ? {2'b11, hold_b9, hold_data}
                               : {1'b1, nine_bit ? hold_b9 : 1'b1, hold_data, 1'b0};
  assign frame_len = sync_mode ? CNT_W'(nine_bit ? DATA_W + 1 : DATA_W)
                               : CNT_W'(nine_bit ? DATA_W + 3 : DATA_W + 2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_data <= '0;
      hold_b9   <= 1'b0;
      hold_full <= 1'b0;
    end else if (wr_strobe) begin
      hold_data <= wr_data;
      hold_b9   <= wr_bit9;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (take || !busy) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_cnt == pre_max) begin
      pre_cnt <= '0;
      div_cnt <= (div_cnt == baud_div) ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_r <= 1'b0;
    else if (take) sclk_r <= 1'b0;
    else if (master && brg_tick) sclk_r <= ~sclk_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else ext_sync <= {ext_sync[1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '1;
      bits_left <= '0;
      busy      <= 1'b0;
    end else if (take) begin
      sr        <= frame_img;
      bits_left <= frame_len;
      busy      <= 1'b1;
    end else if (shift_evt) begin
      sr        <= {1'b1, sr[SR_W-1:1]};
      bits_left <= bits_left - 1'b1;
      if (last_bit) busy <= 1'b0;
    end

  assign ser_out     = busy ? sr[0] : 1'b1;
  assign clk_out     = master & sclk_r;
  assign clk_out_en  = master;
  assign shift_empty = ~busy;
  assign buf_empty   = ~hold_full;

  p_idle_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> !clk_out);
  p_start_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> $past(tx_en));
  p_rx_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !$past(sync_mode && (rx_single_en || rx_cont_en)));
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && $fell(shift_empty)) |-> !ser_out);
  p_strobe_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !buf_empty);
  p_async_no_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> (!clk_out && !clk_out_en));
endmodule

// File: tb/sertx_engine_bench.sv
module sertx_engine_bench;
  logic clk = 0, rst_n = 0;
  logic sync_mode = 0, clk_master = 0, nine_bit = 0, tx_en = 0;
  logic rx_single_en = 0, rx_cont_en = 0, fast_baud = 0;
  logic [7:0] baud_div = 0, wr_data = 0;
  logic wr_bit9 = 0, wr_strobe = 0, ext_clk = 1;
  logic ser_out, clk_out, clk_out_en, shift_empty, buf_empty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sertx_engine u_sertx_engine (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .clk_master(clk_master),
    .nine_bit(nine_bit), .tx_en(tx_en), .rx_single_en(rx_single_en),
    .rx_cont_en(rx_cont_en), .fast_baud(fast_baud), .baud_div(baud_div),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_strobe(wr_strobe), .ext_clk(ext_clk),
    .ser_out(ser_out), .clk_out(clk_out), .clk_out_en(clk_out_en),
    .shift_empty(shift_empty), .buf_empty(buf_empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_data = d; wr_bit9 = b9; wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
  endtask

  task automatic drain();
    while (!(shift_empty && buf_empty)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_start();
    while (ser_out) @(negedge clk);
  endtask

  task automatic async_rx(input int p, input int nb, output logic [31:0] bits);
    bits = '0;
    wait_start();
    repeat (p / 2) @(negedge clk);
    bits[0] = ser_out;
    for (int i = 1; i < nb; i++) begin
      repeat (p) @(negedge clk);
      bits[i] = ser_out;
    end
  endtask

  task automatic t_reset();
    chk("R1 shift_empty", shift_empty, 1);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 ser_out", ser_out, 1);
    chk("R1 clk_out", clk_out, 0);
  endtask

  task automatic t_async_frame();
    logic [31:0] b;
    sync_mode = 0; nine_bit = 0; fast_baud = 0; baud_div = 2; tx_en = 1;
    write_byte(8'hA5, 1'b0);
    async_rx(48, 10, b);
    chk("R2 8-bit frame", b, {22'd0, 1'b1, 8'hA5, 1'b0});
    drain();
    chk("R2 idle high", ser_out, 1);
  endtask

  task automatic t_bit_period(input logic fast, input logic [7:0] d, input int exp);
    int cnt;
    sync_mode = 0; nine_bit = 0; fast_baud = fast; baud_div = d; tx_en = 1;
    write_byte(8'h01, 1'b0);
    wait_start();
    cnt = 0;
    while (!ser_out) begin cnt++; @(negedge clk); end
    chk("R3 bit period", cnt, exp);
    drain();
  endtask

  task automatic t_nine_bit(input logic b9);
    logic [31:0] b;
    sync_mode = 0; nine_bit = 1; fast_baud = 1; baud_div = 0; tx_en = 1;
    write_byte(8'h3C, b9);
    async_rx(4, 11, b);
    chk("R4 9-bit frame", b, {21'd0, 1'b1, b9, 8'h3C, 1'b0});
    drain();
    nine_bit = 0;
  endtask

  task automatic t_enable_gate();
    logic [31:0] b;
    sync_mode = 0; fast_baud = 1; baud_div = 1; tx_en = 0;
    write_byte(8'h77, 1'b0);
    repeat (40) @(negedge clk);
    chk("R5 held shift_empty", shift_empty, 1);
    chk("R5 held buf_empty", buf_empty, 0);
    chk("R5 held ser_out", ser_out, 1);
    tx_en = 1;
    async_rx(8, 10, b);
    chk("R5 sent after enable", b, {22'd0, 1'b1, 8'h77, 1'b0});
    drain();
  endtask

  task automatic t_back_to_back();
    logic [31:0] b;
    sync_mode = 0; fast_baud = 1; baud_div = 1; tx_en = 1;
    write_byte(8'h5A, 1'b0);
    while (!buf_empty) @(negedge clk);
    write_byte(8'hC3, 1'b0);
    chk("R10 buffer full", buf_empty, 0);
    async_rx(8, 20, b);
    chk("R10 back to back", b, {12'd0, 1'b1, 8'hC3, 1'b0, 1'b1, 8'h5A, 1'b0});
    drain();
  endtask

  task automatic t_master();
    logic [31:0] b;
    int cnt;
    sync_mode = 1; clk_master = 1; nine_bit = 0; fast_baud = 1; baud_div = 3; tx_en = 1;
    @(negedge clk);
    chk("R7 clk_out_en", clk_out_en, 1);
    write_byte(8'h96, 1'b0);
    while (shift_empty) @(negedge clk);
    cnt = 0;
    while (!clk_out) begin cnt++; @(negedge clk); end
    chk("R7 half period", cnt, 4);
    b = '0;
    b[0] = ser_out;
    for (int i = 1; i < 8; i++) begin
      while (clk_out) @(negedge clk);
      while (!clk_out) @(negedge clk);
      b[i] = ser_out;
    end
    chk("R7 master data", b, 32'h96);
    drain();
    chk("R7 clock rests low", clk_out, 0);
  endtask

  task automatic t_slave();
    logic [31:0] b;
    sync_mode = 1; clk_master = 0; nine_bit = 1; tx_en = 1; ext_clk = 1;
    @(negedge clk);
    chk("R8 clk_out_en", clk_out_en, 0);
    write_byte(8'h4B, 1'b0);
    while (shift_empty) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R8 holds first bit", {shift_empty, ser_out}, 2'b01);
    b = '0;
    for (int i = 0; i < 9; i++) begin
      repeat (2) @(negedge clk);
      b[i] = ser_out;
      ext_clk = 0;
      repeat (6) @(negedge clk);
      ext_clk = 1;
      repeat (6) @(negedge clk);
    end
    chk("R8 slave data", b, 32'h04B);
    chk("R8 frame done", shift_empty, 1);
    chk("R8 no clock out", clk_out, 0);
    nine_bit = 0;
  endtask

  task automatic t_override();
    logic [31:0] b;
    sync_mode = 1; clk_master = 1; baud_div = 0; tx_en = 1; rx_cont_en = 1;
    write_byte(8'h12, 1'b0);
    repeat (40) @(negedge clk);
    chk("R6 sync override idle", {shift_empty, buf_empty, clk_out}, 3'b100);
    rx_cont_en = 0;
    repeat (3) @(negedge clk);
    chk("R6 starts after release", shift_empty, 0);
    drain();
    sync_mode = 0; clk_master = 0; fast_baud = 1; baud_div = 0; rx_single_en = 1;
    write_byte(8'hE1, 1'b0);
    async_rx(4, 10, b);
    chk("R6 async ignores rx enable", b, {22'd0, 1'b1, 8'hE1, 1'b0});
    drain();
    rx_single_en = 0;
  endtask

  task automatic t_async_master_ignored();
    logic [31:0] b;
    sync_mode = 0; clk_master = 1; fast_baud = 1; baud_div = 1; tx_en = 1;
    write_byte(8'h2D, 1'b0);
    async_rx(8, 10, b);
    chk("R9 frame unchanged", b, {22'd0, 1'b1, 8'h2D, 1'b0});
    chk("R9 clock quiet", {clk_out_en, clk_out}, 2'b00);
    drain();
    clk_master = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_async_frame();
    t_bit_period(1'b0, 8'd2, 48);
    t_bit_period(1'b1, 8'd5, 24);
    t_nine_bit(1'b1);
    t_nine_bit(1'b0);
    t_enable_gate();
    t_back_to_back();
    t_master();
    t_slave();
    t_override();
    t_async_master_ignored();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule